// File: doc/BRIEF.md
# Bus Master Transfer Timeout Watchdog

This block sits beside the protocol engine of a bus master and watches every transfer for a target that stalls. It has two independent checks. The first counts consecutive clock cycles in which a data phase is held waiting for target ready. The second counts retries that the target signals for one transaction. When either count goes past its programmed limit, the block raises a sticky unrecoverable-error status bit. On the same clock it gives a single-cycle pulse that the protocol engine can use to abort the transfer.

Software sets both limits through a byte-wide register port that has combinational read data. The wait limit register holds an 8-bit value. The block shifts that value left by five bits, so the limit in clock cycles is the value times 32. The retry limit register holds the allowed number of retries directly. Writing zero to either register turns that check off. Software clears the status bit by writing 1 to it.

Top module: `xfer_watchdog`

## Requirements
- R1: After reset, offset 40h reads 00h (wait limit), offset 41h reads 80h (retry limit), and offset 42h (status, unrecoverable-error flag in bit 0, other bits zero) reads 00h.
- R2: A write to offset 40h or 41h replaces that register, and the new value reads back at the same offset.
- R3: With a nonzero wait value V, the error is raised when the data phase is waiting (bus_wait high, with no ready, done or retry) for more than V*32 consecutive cycles. Exactly V*32 waiting cycles raise nothing.
- R4: A wait value of 00h disables the ready-wait check, whatever the length of the wait.
- R5: The wait count returns to zero in any cycle with target ready, transaction done or retry, so two waits that are each within the limit, separated by one of these, raise no error.
- R6: With a nonzero retry value L, the error is raised by retry number L+1 of one transaction. A done cycle without a retry resets the retry count.
- R7: A retry value of 00h disables the retry check.
- R8: The status flag is sticky. A write to offset 42h with bit 0 set clears it. A write with bit 0 clear leaves it unchanged. If a new error is detected in the same cycle as the clear, the flag is set.
- R9: ue_pulse is high for one cycle per detected error, on the same cycle that the flag first shows that error. One stall or retry run gives one pulse only.
- R10: Reads of any offset other than 40h, 41h and 42h return 00h. Writes to those offsets change neither limit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| bus_wait | input | 1 | Data phase is waiting for target ready |
| bus_trdy | input | 1 | Target ready seen |
| bus_retry | input | 1 | Target signalled retry |
| bus_done | input | 1 | Transaction completed |
| ue_flag | output | 1 | Sticky unrecoverable-error status |
| ue_pulse | output | 1 | One-cycle error-detected pulse |

## Verification
The bench runs waits of V*32-1, V*32 and V*32+1 cycles for small wait values, so that an off-by-one in the shifted limit shows up as an early or late error. It also runs a long wait with the limit set to zero. Retry runs sweep every retry count from 0 to 6 against retry limits 0 to 4, and compare the result with the arithmetic rule count > limit. Split waits and split retry runs separate a counter that clears correctly from one that does not. The bench counts pulses in each run, which tells a single pulse from a pulse repeated every cycle.

// File: rtl/xfer_watchdog.sv
module xfer_watchdog #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SHIFT = 5,
  parameter logic [AW-1:0] WAIT_OFS  = 8'h40,
  parameter logic [AW-1:0] RETRY_OFS = 8'h41,
  parameter logic [AW-1:0] STAT_OFS  = 8'h42,
  parameter logic [DW-1:0] WAIT_RST  = 8'h00,
  parameter logic [DW-1:0] RETRY_RST = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          bus_wait,
  input  logic          bus_trdy,
  input  logic          bus_retry,
  input  logic          bus_done,
  output logic          ue_flag,
  output logic          ue_pulse
);
  localparam int CW = DW + SHIFT;
  localparam logic [DW-1:0] RMAX = '1;

  logic [DW-1:0] wait_r, retry_r, rcnt;
  logic [CW-1:0] wcnt, wlim;
  logic wtrip, rtrip, wait_clr, wait_hit, retry_hit, err, clr_wr;

  assign wlim      = CW'(wait_r) << SHIFT;
  assign wait_clr  = bus_trdy | bus_done | bus_retry;
  assign wait_hit  = (wait_r != '0) && bus_wait && !wait_clr && !wtrip && (wcnt >= wlim);
  assign retry_hit = bus_retry && (retry_r != '0) && !rtrip && (rcnt >= retry_r);
  assign err       = wait_hit | retry_hit;
  assign clr_wr    = reg_wr && (reg_addr == STAT_OFS) && reg_wdata[0];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == WAIT_OFS)       reg_rdata = wait_r;
    else if (reg_addr == RETRY_OFS) reg_rdata = retry_r;
    else if (reg_addr == STAT_OFS)  reg_rdata = DW'(ue_flag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_r  <= WAIT_RST;
      retry_r <= RETRY_RST;
    end else if (reg_wr) begin
      if (reg_addr == WAIT_OFS)  wait_r  <= reg_wdata;
      if (reg_addr == RETRY_OFS) retry_r <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt  <= '0;
      wtrip <= 1'b0;
    end else if (wait_clr) begin
      wcnt  <= '0;
      wtrip <= 1'b0;
    end else if (bus_wait) begin
      if (wait_hit)         wtrip <= 1'b1;
      else if (wcnt < wlim) wcnt  <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt  <= '0;
      rtrip <= 1'b0;
    end else if (bus_retry) begin
      if (rcnt != RMAX) rcnt <= rcnt + 1'b1;
      if (retry_hit)    rtrip <= 1'b1;
    end else if (bus_done) begin
      rcnt  <= '0;
      rtrip <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ue_flag  <= 1'b0;
      ue_pulse <= 1'b0;
    end else begin
      ue_pulse <= err;
      ue_flag  <= err | (ue_flag & ~clr_wr);
    end
  end
endmodule

module xfer_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [7:0] wait_r,
  input logic [7:0] retry_r,
  input logic       ue_flag,
  input logic       ue_pulse
);
  // R9
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ue_pulse |-> ue_flag);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_flag && !(reg_wr && reg_addr == 8'h42 && reg_wdata[0])) |=> ue_flag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h42 && reg_wdata[0]) |=> (ue_pulse || !ue_flag));
  // R4
  both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_r == 8'h00 && retry_r == 8'h00) |=> !ue_pulse);
  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 8'h40 && reg_addr != 8'h41 && reg_addr != 8'h42) |-> reg_rdata == 8'h00);
  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h41) |=> retry_r == $past(reg_wdata));
endmodule

bind xfer_watchdog xfer_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wait_r(wait_r),
  .retry_r(retry_r), .ue_flag(ue_flag), .ue_pulse(ue_pulse)
);

// File: tb/test_xfer_watchdog.sv
module test_xfer_watchdog;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic reg_wr = 0, bus_wait = 0, bus_trdy = 0, bus_retry = 0, bus_done = 0;
  logic [7:0] reg_rdata;
  logic ue_flag, ue_pulse;
  int checks = 0, fails = 0, pcount = 0;

  always #4 clk = ~clk;

  xfer_watchdog i_xfer_watchdog (.*);

  always @(negedge clk) if (rst_n && ue_pulse) pcount++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0; reg_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic start_run();
    wr(8'h42, 8'h01);
    @(negedge clk); pcount = 0;
  endtask

  task automatic waits(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); bus_wait = 1; end
    @(negedge clk); bus_wait = 0;
  endtask

  task automatic pulse_sig(input int which);
    @(negedge clk);
    if (which == 0) bus_trdy = 1; else if (which == 1) bus_retry = 1; else bus_done = 1;
    @(negedge clk); bus_trdy = 0; bus_retry = 0; bus_done = 0;
  endtask

  task automatic end_run(input string req, input int exp_flag);
    logic [7:0] s;
    @(negedge clk); @(negedge clk);
    rd(8'h42, s);
    chk(req, s, exp_flag);
    chk("R9", pcount, exp_flag);
    pulse_sig(2);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h40, d); chk("R1", d, 8'h00);
    rd(8'h41, d); chk("R1", d, 8'h80);
    rd(8'h42, d); chk("R1", d, 8'h00);
    chk("R1", ue_pulse, 0);

    wr(8'h40, 8'h5A); rd(8'h40, d); chk("R2", d, 8'h5A);
    wr(8'h41, 8'hC3); rd(8'h41, d); chk("R2", d, 8'hC3);

    wr(8'h43, 8'hFF); wr(8'h00, 8'hFF);
    rd(8'h40, d); chk("R10", d, 8'h5A);
    rd(8'h41, d); chk("R10", d, 8'hC3);
    rd(8'h43, d); chk("R10", d, 8'h00);
    rd(8'hFF, d); chk("R10", d, 8'h00);

    wr(8'h41, 8'h00);
    for (int v = 1; v <= 3; v++) begin
      wr(8'h40, 8'(v));
      for (int k = -1; k <= 1; k++) begin
        start_run(); waits(v * 32 + k);
        end_run("R3", (v * 32 + k > v * 32) ? 1 : 0);
      end
    end

    wr(8'h40, 8'h00);
    start_run(); waits(300); end_run("R4", 0);

    wr(8'h40, 8'h01);
    for (int s = 0; s < 3; s++) begin
      start_run(); waits(30); pulse_sig(s); waits(30); end_run("R5", 0);
    end

    wr(8'h40, 8'h00);
    for (int l = 0; l <= 4; l++) begin
      wr(8'h41, 8'(l));
      for (int r = 0; r <= 6; r++) begin
        start_run();
        for (int i = 0; i < r; i++) pulse_sig(1);
        end_run(l == 0 ? "R7" : "R6", (l != 0 && r > l) ? 1 : 0);
      end
    end

    wr(8'h41, 8'h02);
    start_run();
    pulse_sig(1); pulse_sig(1); pulse_sig(2); pulse_sig(1); pulse_sig(1);
    end_run("R6", 0);

    start_run();
    for (int i = 0; i < 3; i++) pulse_sig(1);
    @(negedge clk); @(negedge clk);
    wr(8'h42, 8'h00);
    rd(8'h42, d); chk("R8", d, 1);
    repeat (5) @(negedge clk);
    rd(8'h42, d); chk("R8", d, 1);
    wr(8'h42, 8'h01);
    rd(8'h42, d); chk("R8", d, 0);
    pulse_sig(2);

    wr(8'h41, 8'h01);
    pulse_sig(1);
    @(negedge clk);
    reg_addr = 8'h42; reg_wdata = 8'h01; reg_wr = 1; bus_retry = 1;
    @(negedge clk); reg_wr = 0; bus_retry = 0;
    rd(8'h42, d); chk("R8", d, 1);
    pulse_sig(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule